// File: doc/BRIEF.md
# Four-Way Serial Hit-Frame Interleaver

This block merges several lock-step front-end serial hit streams onto one serial lane that runs N_SRC times faster. Every source sends fixed-length frames: a short digital header followed by a block of binary hit bits. The frame length never depends on how many strips fired. All sources start their frames on the same slot, so the block needs no elastic buffering: it captures one bit from every source per slot and replays them on the lane, one source per lane clock.

The block runs on the lane clock. A clock enable (`slot_en`) marks the one lane cycle in every N_SRC where the input bits are valid. A frame-start strobe given together with that enable opens a frame. The block then counts header and hit groups and returns to idle once the last hit group has been sent. While idle the lane carries constant zeros. A one-cycle marker flags the lane cycle that carries source 0 of the first header bit.

A frame-control FSM has three states. IDLE→HEADER is taken on a slot with the frame strobe. HEADER→PAYLOAD is taken on the slot after the last header group. PAYLOAD→IDLE is taken on the slot after the last hit group. Any state goes to HEADER on a slot with the frame strobe, which is the restart transition.

Top module: `hitlane_interleaver`

## Requirements
- R1: While reset is held, and after it until the first frame opens, `lane_bit` and `lane_sof` are 0.
- R2: A group captured on a slot (`slot_en`=1) appears on `lane_bit` starting one lane cycle later, source 0 first and then sources 1 to N_SRC-1, one source per consecutive lane cycle.
- R3: `lane_sof` is 1 only in the lane cycle that carries source 0 of the first header group of a frame, and it lasts exactly one cycle.
- R4: A frame spans exactly HDR_W+HIT_W slots counted from the slot with the frame strobe. On later slots with no strobe, `src_bits` are ignored and the lane stays 0.
- R5: In IDLE, a slot without the frame strobe has no effect and the lane stays 0.
- R6: A frame strobe on the slot right after a frame's last hit group opens a new frame with no idle slot between the two frames.
- R7: A frame strobe in the middle of a frame restarts the frame. It raises `lane_sof` again, and the full HDR_W+HIT_W slots are counted from the strobe.
- R8: If no new slot arrives within N_SRC lane cycles of the last one, the lane outputs 0 and `lane_sof` stays 0 in the extra cycles.
- R9: `frm_start` has no effect in a cycle where `slot_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Input bits valid in this lane cycle (one cycle in every N_SRC) |
| frm_start | input | 1 | With `slot_en`, this slot carries the first header bit |
| src_bits | input | N_SRC | One serial bit from each source; bit i belongs to source i |
| lane_bit | output | 1 | Interleaved serial lane |
| lane_sof | output | 1 | Marks the lane cycle holding source 0 of the first header bit |

## Verification
The bench builds the block with N_SRC=4, HDR_W=2 and HIT_W=6, so a frame takes only eight slots, or 32 lane cycles. With frames this short, every transition of the FSM can be reached in a few hundred cycles: restart, back-to-back frames, idle slots and late slots. The group pattern rotates through all sixteen 4-bit values across the frames, so every source position is seen as both 0 and 1 in header and hit groups.

// File: rtl/hli_pkg.sv
package hli_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2
    } hli_state_e;
endpackage

// File: rtl/hli_slot_timer.sv
// Lane-cycle position within a slot; saturates at N_SRC when no new slot arrives.
module hli_slot_timer #(
    parameter int N_SRC = 4,
    localparam int IW = $clog2(N_SRC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_en,
    output logic [IW-1:0] slot_idx,
    output logic          slot_live
);
    localparam logic [IW-1:0] IDX_DONE = IW'(N_SRC);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= IDX_DONE;
        else if (slot_en)
            idx_q <= '0;
        else if (idx_q != IDX_DONE)
            idx_q <= idx_q + 1'b1;
    end

    assign slot_idx  = idx_q;
    assign slot_live = (idx_q != IDX_DONE);
endmodule

// File: rtl/hli_frame_ctrl.sv
// Frame-control FSM: counts captured groups through header and hit payload.
module hli_frame_ctrl
    import hli_pkg::*;
#(
    parameter int HDR_W = 2,
    parameter int HIT_W = 128,
    localparam int FRAME_W = HDR_W + HIT_W,
    localparam int CW = $clog2(FRAME_W + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_en,
    input  logic       frm_start,
    output hli_state_e state,
    output logic       load,
    output logic       active,
    output logic       first_grp
);
    localparam logic [CW-1:0] HDR_LAST = CW'(HDR_W);
    localparam logic [CW-1:0] FRM_LAST = CW'(FRAME_W);
    localparam logic [CW-1:0] ONE      = CW'(1);

    hli_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (slot_en) begin
            if (frm_start) begin
                st_d  = ST_HEADER;
                cnt_d = ONE;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        st_d = ST_IDLE;
                    end
                    ST_HEADER: begin
                        if (cnt_q == HDR_LAST)
                            st_d = ST_PAYLOAD;
                        cnt_d = cnt_q + 1'b1;
                    end
                    ST_PAYLOAD: begin
                        if (cnt_q == FRM_LAST) begin
                            st_d  = ST_IDLE;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        state     = st_q;
        load      = slot_en && (st_d != ST_IDLE);
        active    = (st_q != ST_IDLE);
        first_grp = (st_q == ST_HEADER) && (cnt_q == ONE);
    end
endmodule

// File: rtl/hli_lane_mux.sv
// Holds one captured group and presents it one source per lane cycle.
module hli_lane_mux #(
    parameter int N_SRC = 4,
    localparam int IW = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N_SRC-1:0] src_bits,
    input  logic [IW-1:0]    slot_idx,
    input  logic             slot_live,
    input  logic             active,
    input  logic             first_grp,
    output logic             lane_bit,
    output logic             lane_sof
);
    logic [N_SRC-1:0] hold_q;
    logic             sel;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (load)
            hold_q <= src_bits;
    end

    always_comb begin
        sel = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (slot_idx == IW'(i))
                sel = hold_q[i];
        end
    end

    assign lane_bit = active && slot_live && sel;
    assign lane_sof = active && first_grp && (slot_idx == '0);
endmodule

// File: rtl/hitlane_interleaver.sv
module hitlane_interleaver
    import hli_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int HDR_W = 2,
    parameter int HIT_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_en,
    input  logic             frm_start,
    input  logic [N_SRC-1:0] src_bits,
    output logic             lane_bit,
    output logic             lane_sof
);
    localparam int IW = $clog2(N_SRC + 1);

    logic [IW-1:0] slot_idx;
    logic          slot_live;
    hli_state_e    state;
    logic          load;
    logic          active;
    logic          first_grp;

    hli_slot_timer #(.N_SRC(N_SRC)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .slot_idx  (slot_idx),
        .slot_live (slot_live)
    );

    hli_frame_ctrl #(.HDR_W(HDR_W), .HIT_W(HIT_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .frm_start (frm_start),
        .state     (state),
        .load      (load),
        .active    (active),
        .first_grp (first_grp)
    );

    hli_lane_mux #(.N_SRC(N_SRC)) mux_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .src_bits  (src_bits),
        .slot_idx  (slot_idx),
        .slot_live (slot_live),
        .active    (active),
        .first_grp (first_grp),
        .lane_bit  (lane_bit),
        .lane_sof  (lane_sof)
    );
endmodule

// File: rtl/hitlane_interleaver_chk.sv
module hitlane_interleaver_chk #(
    parameter int N_SRC = 4,
    parameter int HDR_W = 2,
    parameter int HIT_W = 128
) (
    input logic clk,
    input logic rst_n,
    input logic slot_en,
    input logic frm_start,
    input logic lane_bit,
    input logic lane_sof
);
    localparam int FRAME_W = HDR_W + HIT_W;
    localparam int GW = $clog2(N_SRC + 2);
    localparam int FW = $clog2(FRAME_W + 2);
    localparam logic [GW-1:0] GAP_SAT = GW'(N_SRC);
    localparam logic [FW-1:0] FRM_OUT = FW'(FRAME_W + 1);
    localparam logic [FW-1:0] FRM_END = FW'(FRAME_W);

    logic [GW-1:0] gap_cnt;
    logic [FW-1:0] frm_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= GAP_SAT;
            frm_cnt <= FRM_OUT;
        end else begin
            if (slot_en)
                gap_cnt <= '0;
            else if (gap_cnt != GAP_SAT)
                gap_cnt <= gap_cnt + 1'b1;
            if (slot_en) begin
                if (frm_start)
                    frm_cnt <= FW'(1);
                else if (frm_cnt <= FRM_END)
                    frm_cnt <= frm_cnt + 1'b1;
            end
        end
    end

    a_r3_sof_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        lane_sof |-> $past(slot_en));

    a_r3_sof_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        lane_sof |-> $past(frm_start));

    a_r3_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        lane_sof |=> !lane_sof);

    a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt == GAP_SAT) |-> (!lane_bit && !lane_sof));

    a_r4_quiet_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_cnt == FRM_OUT) |-> (!lane_bit && !lane_sof));
endmodule

bind hitlane_interleaver hitlane_interleaver_chk #(
    .N_SRC(N_SRC), .HDR_W(HDR_W), .HIT_W(HIT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_en   (slot_en),
    .frm_start (frm_start),
    .lane_bit  (lane_bit),
    .lane_sof  (lane_sof)
);

// File: tb/hitlane_interleaver_tb_top.sv
module hitlane_interleaver_tb_top;
    localparam int N_SRC   = 4;
    localparam int HDR_W   = 2;
    localparam int HIT_W   = 6;
    localparam int FRAME_W = HDR_W + HIT_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             slot_en;
    logic             frm_start;
    logic [N_SRC-1:0] src_bits;
    logic             lane_bit;
    logic             lane_sof;

    int n_chk  = 0;
    int n_fail = 0;
    int grp_seq = 0;
    bit done = 1'b0;

    // bench model of the frame
    bit m_act   = 1'b0;
    bit m_first = 1'b0;
    int m_cnt   = 0;

    always #5 clk = ~clk;

    hitlane_interleaver #(.N_SRC(N_SRC), .HDR_W(HDR_W), .HIT_W(HIT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .frm_start (frm_start),
        .src_bits  (src_bits),
        .lane_bit  (lane_bit),
        .lane_sof  (lane_sof)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, got, exp);
        end
    endtask

    // Drive one slot at the current negedge, then check the N_SRC lane cycles.
    task automatic do_slot(input string tag, input bit start, input logic [N_SRC-1:0] grp);
        if (start) begin
            m_act = 1'b1; m_first = 1'b1; m_cnt = 1;
        end else if (m_act) begin
            m_first = 1'b0;
            if (m_cnt == FRAME_W) m_act = 1'b0;
            else m_cnt++;
        end
        slot_en = 1'b1; frm_start = start; src_bits = grp;
        for (int j = 0; j < N_SRC; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (j == 0) begin
                slot_en = 1'b0; frm_start = 1'b0; src_bits = ~grp;
            end
            chk({tag, " lane_bit"}, lane_bit, m_act ? grp[j] : 1'b0);
            chk({tag, " lane_sof"}, lane_sof, (m_act && m_first && j == 0));
        end
    endtask

    function automatic logic [N_SRC-1:0] next_grp();
        logic [N_SRC-1:0] g;
        g = N_SRC'((grp_seq * 7 + 3) % 16);
        grp_seq++;
        return g;
    endfunction

    task automatic full_frame(input string tag);
        do_slot({tag, " R3 first"}, 1'b1, next_grp());
        for (int b = 1; b < FRAME_W; b++)
            do_slot({tag, " R2"}, 1'b0, next_grp());
    endtask

    task automatic gap(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R8 gap lane_bit", lane_bit, 1'b0);
            chk("R8 gap lane_sof", lane_sof, 1'b0);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; slot_en = 1'b0; frm_start = 1'b0; src_bits = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset lane_bit", lane_bit, 1'b0);
        chk("R1 reset lane_sof", lane_sof, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 post-reset lane_bit", lane_bit, 1'b0);
        chk("R1 post-reset lane_sof", lane_sof, 1'b0);

        // R5: idle slot with all-ones inputs ignored
        do_slot("R5 idle", 1'b0, '1);

        // R9: frame strobe without slot enable ignored
        frm_start = 1'b1; src_bits = '1;
        @(posedge clk); @(negedge clk);
        frm_start = 1'b0;
        chk("R9 lone strobe lane_bit", lane_bit, 1'b0);
        chk("R9 lone strobe lane_sof", lane_sof, 1'b0);
        do_slot("R9 after strobe", 1'b0, '1);

        // R2/R3: first full frame, then idle slots
        full_frame("A");
        do_slot("R4 after frame", 1'b0, '1);
        do_slot("R4 after frame", 1'b0, 4'b1010);

        // R6: back-to-back frames
        full_frame("R6 B");
        full_frame("R6 C");
        do_slot("R4 after C", 1'b0, '1);

        // R7: restart in the middle of a frame
        do_slot("R7 D first", 1'b1, next_grp());
        do_slot("R7 D", 1'b0, next_grp());
        do_slot("R7 D", 1'b0, next_grp());
        full_frame("R7 E");
        do_slot("R7 R4 after E", 1'b0, '1);

        // R8: late slots inside a frame
        do_slot("R8 F first", 1'b1, next_grp());
        gap(3);
        do_slot("R8 F", 1'b0, 4'b1111);
        gap(1);
        for (int b = 2; b < FRAME_W; b++)
            do_slot("R8 F", 1'b0, next_grp());
        do_slot("R8 R4 after F", 1'b0, '1);

        // sweep remaining group values through two more frames
        full_frame("G");
        full_frame("H");
        do_slot("R4 after H", 1'b0, '1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule